// File: doc/BRIEF.md
# Pipelined synchronous dual-port RAM

This block is a true dual-port memory with two fully independent clocked ports. Each port registers its address, write data, byte-lane enables, write strobe, output enable and a pair of chip selects of opposite polarity on the rising edge of its own clock. The access then runs in the following cycle, and read data lands in an output register. No combinational path leads from an address pin to a data pin. Either port can read or write any word, and both can work on the same word in the same cycle.

A port whose chip selects are not both active in a cycle does nothing in that cycle. That cycle's output slot is turned off, and the outputs only come back for a slot in which the port was selected. Writes have byte granularity: each 9-bit lane of the word has its own enable. The storage is built from two banks, one written by each port, and a read combines them with XOR. Each bank therefore has a single writer and a single clock. A shared active-low asynchronous reset clears the pipeline and output state of both ports and leaves the stored words as they were.

Top module: `dpr_core`

## Requirements
- R1: A read is a cycle with cs_n=0, cs=1, we=0 and oe=1. After the second rising edge that follows the read, rdata holds the word at addr and rvalid is 1, for exactly that one slot.
- R2: A cycle with cs_n=1 or cs=0 performs no access: no word changes even when we=1. Two edges later, rdata is 0 and rvalid is 0.
- R3: After one or more deselected cycles, the next selected read cycle drives its data and rvalid again with the latency of R1.
- R4: A write (cs_n=0, cs=1, we=1) updates only the lanes whose be bit is 1. be bit l covers data bits [9l+8:9l]. All other lanes keep their previous contents.
- R5: A cycle with oe=0 makes its output slot rdata=0 and rvalid=0, whatever the access does.
- R6: In the output slot of a selected write cycle with oe=1, rdata keeps presenting the word from that port's last read, and rvalid is 0.
- R7: When one port writes a word in the same cycle as the other port reads it, the reader gets the old contents. A later read gets the new contents.
- R8: Both ports can read the same word in the same cycle and get equal data. A word written by one port can be read by the other.
- R9: While rst_n is 0, rdata and rvalid of both ports are 0, and a read still in flight is dropped. Stored words survive the reset.
- R10: When both ports write the same word in the same cycle, that word's contents are undefined. Every other word is left intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset of both port pipelines |
| clk_a | input | 1 | Port A clock |
| cs_n_a | input | 1 | Port A chip select, active low |
| cs_a | input | 1 | Port A chip select, active high |
| we_a | input | 1 | Port A write strobe (1 = write, 0 = read) |
| be_a | input | LANES | Port A byte-lane write enables |
| addr_a | input | AW | Port A word address |
| wdata_a | input | 9*LANES | Port A write data |
| oe_a | input | 1 | Port A output enable for this cycle's slot |
| rdata_a | output | 9*LANES | Port A read data, 0 when the slot is not driven |
| rvalid_a | output | 1 | Port A read data valid |
| clk_b | input | 1 | Port B clock |
| cs_n_b | input | 1 | Port B chip select, active low |
| cs_b | input | 1 | Port B chip select, active high |
| we_b | input | 1 | Port B write strobe (1 = write, 0 = read) |
| be_b | input | LANES | Port B byte-lane write enables |
| addr_b | input | AW | Port B word address |
| wdata_b | input | 9*LANES | Port B write data |
| oe_b | input | 1 | Port B output enable for this cycle's slot |
| rdata_b | output | 9*LANES | Port B read data, 0 when the slot is not driven |
| rvalid_b | output | 1 | Port B read data valid |

## Verification
The assertions check on every cycle the properties that follow from a port's own inputs:
- a selected read with its output enabled yields rvalid two edges later;
- a deselected cycle or a cycle with oe low yields a silent slot;
- a lane with its enable off keeps its bank contents through a write;
- outputs are clear while reset is held.

Only the bench's scenarios, compared against a behavioural model every clock, can show that the right data comes back. That covers the lane merging seen through the XOR of both banks, old-data returns when one port reads while the other writes, cross-port visibility, the held word during write slots, data surviving a reset, and neighbouring words staying intact after a same-word write collision.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_READ  = 2'd1,
    SLOT_WRITE = 2'd2
  } slot_e;

  // A port is selected only when the low-active select is low and the
  // high-active select is high.
  function automatic logic chip_on(input logic sel_lo_n, input logic sel_hi);
    return !sel_lo_n && sel_hi;
  endfunction

  function automatic slot_e slot_kind(input logic sel_lo_n, input logic sel_hi,
                                      input logic wr);
    if (!chip_on(sel_lo_n, sel_hi)) return SLOT_IDLE;
    return wr ? SLOT_WRITE : SLOT_READ;
  endfunction
endpackage

// File: rtl/dpr_bank.sv
// One storage bank. Only its own port writes it, so it has one clock and one
// writer. A lane stores (new data XOR peer bank), so that the XOR of both
// banks yields the last value written by either port.
module dpr_bank
  import dpr_pkg::*;
#(
  parameter  int LANES = 2,
  parameter  int AW    = 6,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_be,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    peer_word,
  input  logic [AW-1:0]    xaddr,
  output logic [DW-1:0]    word_own,
  output logic [DW-1:0]    word_x
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] chk_addr;
  logic [DW-1:0] chk_word;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be[l])
          mem[wr_addr][l*LANE_W +: LANE_W] <=
            wr_data[l*LANE_W +: LANE_W] ^ peer_word[l*LANE_W +: LANE_W];
      end
    end
  end

  assign word_own = mem[wr_addr];
  assign word_x   = mem[xaddr];

  // Word at the address written one edge ago, for the lane check below.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_addr <= '0;
    else        chk_addr <= wr_addr;
  end
  assign chk_word = mem[chk_addr];

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    p_lane_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_be[l]) |=>
        chk_word[l*LANE_W +: LANE_W] == $past(word_own[l*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/dpr_port.sv
// Per-port pipeline: input register stage, then the access and output stage.
module dpr_port
  import dpr_pkg::*;
#(
  parameter  int LANES = 2,
  parameter  int AW    = 6,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cs,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             oe,
  output logic [AW-1:0]    acc_addr,
  output logic             acc_wr,
  output logic [LANES-1:0] acc_be,
  output logic [DW-1:0]    acc_wdata,
  input  logic [DW-1:0]    arr_word,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  slot_e            slot_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] be_q;
  logic [DW-1:0]    wdata_q;
  logic             oe_q;

  logic             drive_q;
  logic             rvld_q;
  logic             oe2_q;
  logic [DW-1:0]    rd_q;

  logic             read_issue;
  logic             slot_on;

  // Stage 1: every input captured on the rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SLOT_IDLE;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      slot_q  <= slot_kind(cs_n, cs, we);
      addr_q  <= addr;
      be_q    <= be;
      wdata_q <= wdata;
      oe_q    <= oe;
    end
  end

  assign read_issue = (slot_q == SLOT_READ);
  assign slot_on    = (slot_q != SLOT_IDLE);
  assign acc_addr   = addr_q;
  assign acc_wr     = (slot_q == SLOT_WRITE);
  assign acc_be     = be_q;
  assign acc_wdata  = wdata_q;

  // Stage 2: array read into the output register. Driver state follows the slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      rvld_q  <= 1'b0;
      oe2_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      drive_q <= slot_on;
      rvld_q  <= read_issue;
      oe2_q   <= oe_q;
      if (read_issue) rd_q <= arr_word;
    end
  end

  assign rdata  = (drive_q && oe2_q) ? rd_q : '0;
  assign rvalid = drive_q && oe2_q && rvld_q;

  p_read_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs && !we && oe) |-> ##2 rvalid);

  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cs) |-> ##2 (!rvalid && rdata == '0));

  p_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> ##2 (!rvalid && rdata == '0));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r9: assert (!rvalid && rdata == '0);
    end
  end
endmodule

// File: rtl/dpr_core.sv
module dpr_core
  import dpr_pkg::*;
#(
  parameter  int LANES = 2,
  parameter  int AW    = 6,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             rst_n,
  input  logic             clk_a,
  input  logic             cs_n_a,
  input  logic             cs_a,
  input  logic             we_a,
  input  logic [LANES-1:0] be_a,
  input  logic [AW-1:0]    addr_a,
  input  logic [DW-1:0]    wdata_a,
  input  logic             oe_a,
  output logic [DW-1:0]    rdata_a,
  output logic             rvalid_a,
  input  logic             clk_b,
  input  logic             cs_n_b,
  input  logic             cs_b,
  input  logic             we_b,
  input  logic [LANES-1:0] be_b,
  input  logic [AW-1:0]    addr_b,
  input  logic [DW-1:0]    wdata_b,
  input  logic             oe_b,
  output logic [DW-1:0]    rdata_b,
  output logic             rvalid_b
);
  logic [AW-1:0]    xaddr_a, xaddr_b;
  logic             xwr_a, xwr_b;
  logic [LANES-1:0] xbe_a, xbe_b;
  logic [DW-1:0]    xwd_a, xwd_b;
  logic [DW-1:0]    ka_own, ka_x, kb_own, kb_x;
  logic [DW-1:0]    word_a, word_b;

  // Logical word seen by each port: XOR of both banks at that port's address.
  assign word_a = ka_own ^ kb_x;
  assign word_b = kb_own ^ ka_x;

  dpr_port #(.LANES(LANES), .AW(AW)) u_port_a (
    .clk(clk_a), .rst_n(rst_n), .cs_n(cs_n_a), .cs(cs_a), .we(we_a),
    .be(be_a), .addr(addr_a), .wdata(wdata_a), .oe(oe_a),
    .acc_addr(xaddr_a), .acc_wr(xwr_a), .acc_be(xbe_a), .acc_wdata(xwd_a),
    .arr_word(word_a), .rdata(rdata_a), .rvalid(rvalid_a)
  );

  dpr_port #(.LANES(LANES), .AW(AW)) u_port_b (
    .clk(clk_b), .rst_n(rst_n), .cs_n(cs_n_b), .cs(cs_b), .we(we_b),
    .be(be_b), .addr(addr_b), .wdata(wdata_b), .oe(oe_b),
    .acc_addr(xaddr_b), .acc_wr(xwr_b), .acc_be(xbe_b), .acc_wdata(xwd_b),
    .arr_word(word_b), .rdata(rdata_b), .rvalid(rvalid_b)
  );

  dpr_bank #(.LANES(LANES), .AW(AW)) u_bank_a (
    .clk(clk_a), .rst_n(rst_n), .wr_en(xwr_a), .wr_be(xbe_a),
    .wr_addr(xaddr_a), .wr_data(xwd_a), .peer_word(kb_x),
    .xaddr(xaddr_b), .word_own(ka_own), .word_x(ka_x)
  );

  dpr_bank #(.LANES(LANES), .AW(AW)) u_bank_b (
    .clk(clk_b), .rst_n(rst_n), .wr_en(xwr_b), .wr_be(xbe_b),
    .wr_addr(xaddr_b), .wr_data(xwd_b), .peer_word(ka_x),
    .xaddr(xaddr_a), .word_own(kb_own), .word_x(kb_x)
  );
endmodule

// File: tb/test_dpr_core.sv
module test_dpr_core;
  localparam int LANES = 2;
  localparam int AW    = 6;
  localparam int LW    = 9;
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;
  localparam time TCK  = 20ns;

  typedef struct packed {
    logic             cs_n;
    logic             cs;
    logic             we;
    logic [LANES-1:0] be;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    wdata;
    logic             oe;
  } cmd_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  cmd_t drv [2];
  logic [DW-1:0] rd_o [2];
  logic          rv_o [2];

  int total = 0;
  int bad   = 0;
  string phase = "R9";

  // Reference model state.
  logic [DW-1:0] m [DEPTH];
  bit            unk [DEPTH];
  cmd_t          s1 [2];
  logic [DW-1:0] exp_d [2];
  logic          exp_v [2];
  bit            exp_dc [2];
  logic [DW-1:0] last_rd [2];
  bit            last_unk [2];
  int unsigned   seed = 32'h1234abcd;

  always #(TCK/2) clk = ~clk;

  dpr_core #(.LANES(LANES), .AW(AW)) i_dpr_core (
    .rst_n(rst_n),
    .clk_a(clk), .cs_n_a(drv[0].cs_n), .cs_a(drv[0].cs), .we_a(drv[0].we),
    .be_a(drv[0].be), .addr_a(drv[0].addr), .wdata_a(drv[0].wdata), .oe_a(drv[0].oe),
    .rdata_a(rd_o[0]), .rvalid_a(rv_o[0]),
    .clk_b(clk), .cs_n_b(drv[1].cs_n), .cs_b(drv[1].cs), .we_b(drv[1].we),
    .be_b(drv[1].be), .addr_b(drv[1].addr), .wdata_b(drv[1].wdata), .oe_b(drv[1].oe),
    .rdata_b(rd_o[1]), .rvalid_b(rv_o[1])
  );

  function automatic cmd_t c_idle();
    return '{cs_n: 1'b1, cs: 1'b1, we: 1'b0, be: '0, addr: '0, wdata: '0, oe: 1'b1};
  endfunction

  function automatic cmd_t c_rd(input int a, input bit oe = 1'b1);
    return '{cs_n: 1'b0, cs: 1'b1, we: 1'b0, be: '0, addr: AW'(a), wdata: '0, oe: oe};
  endfunction

  function automatic cmd_t c_wr(input int a, input logic [DW-1:0] d,
                                input logic [LANES-1:0] be = '1);
    return '{cs_n: 1'b0, cs: 1'b1, we: 1'b1, be: be, addr: AW'(a), wdata: d, oe: 1'b1};
  endfunction

  // Deselected command that would otherwise write (via cs_n high or cs low).
  function automatic cmd_t c_offwr(input int a, input logic [DW-1:0] d, input bit by_low);
    cmd_t c;
    c = c_wr(a, d);
    if (by_low) c.cs = 1'b0; else c.cs_n = 1'b1;
    return c;
  endfunction

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 7919 + 301) ^ 18'h2a5a5;
  endfunction

  task automatic chk(input string tag, input int p, input logic [DW-1:0] ed,
                     input logic ev, input bit dc);
    total++;
    if (rv_o[p] !== ev || (!dc && rd_o[p] !== ed)) begin
      bad++;
      $display("FAIL %s port%0d: rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
               tag, p, rd_o[p], rv_o[p], ed, ev);
    end
  endtask

  // Execute the captured slots of both ports as they happen at the next edge.
  task automatic advance();
    bit sel [2];
    for (int p = 0; p < 2; p++) begin
      sel[p] = !s1[p].cs_n && s1[p].cs;
      if (!sel[p]) begin
        exp_d[p] = '0; exp_v[p] = 1'b0; exp_dc[p] = 1'b0;
      end else begin
        if (!s1[p].we) begin
          last_rd[p]  = m[s1[p].addr];
          last_unk[p] = unk[s1[p].addr];
        end
        if (s1[p].oe) begin
          exp_d[p] = last_rd[p]; exp_v[p] = !s1[p].we; exp_dc[p] = last_unk[p];
        end else begin
          exp_d[p] = '0; exp_v[p] = 1'b0; exp_dc[p] = 1'b0;
        end
      end
    end
    for (int p = 0; p < 2; p++) begin
      if (sel[p] && s1[p].we) begin
        for (int l = 0; l < LANES; l++)
          if (s1[p].be[l]) m[s1[p].addr][l*LW +: LW] = s1[p].wdata[l*LW +: LW];
        if (s1[p].be == '1) unk[s1[p].addr] = 1'b0;
      end
    end
    if (sel[0] && sel[1] && s1[0].we && s1[1].we && s1[0].addr == s1[1].addr)
      unk[s1[0].addr] = 1'b1;
  endtask

  task automatic cyc(input cmd_t ca, input cmd_t cb);
    @(negedge clk);
    for (int p = 0; p < 2; p++) chk(phase, p, exp_d[p], exp_v[p], exp_dc[p]);
    advance();
    drv[0] = ca; drv[1] = cb;
    s1[0]  = ca; s1[1]  = cb;
  endtask

  task automatic flush();
    repeat (2) cyc(c_idle(), c_idle());
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst_n = 1'b0;
    for (int p = 0; p < 2; p++) begin
      drv[p] = c_idle(); s1[p] = c_idle();
      exp_d[p] = '0; exp_v[p] = 1'b0; exp_dc[p] = 1'b0;
      last_rd[p] = '0; last_unk[p] = 1'b0;
    end
    #1;
    for (int p = 0; p < 2; p++) chk("R9 reset", p, '0, 1'b0, 1'b0);
    repeat (n) begin
      @(negedge clk);
      for (int p = 0; p < 2; p++) chk("R9 reset", p, '0, 1'b0, 1'b0);
    end
    rst_n = 1'b1;
  endtask

  function automatic cmd_t rnd_cmd(inout int unsigned s);
    cmd_t c;
    s = s * 32'd1664525 + 32'd1013904223;
    case (s[31:30])
      2'd0, 2'd1: c = c_rd(int'(s[19:16]), s[29:27] != 3'd0);
      2'd2:       c = c_wr(int'(s[19:16]), DW'(s[17:0] ^ s[29:12]), LANES'(s[25:24] | 2'b01 << s[26]));
      default:    c = c_offwr(int'(s[19:16]), DW'(s[17:0]), s[28]);
    endcase
    return c;
  endfunction

  initial begin
    #(TCK * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m[i] = '0; unk[i] = 1'b0; end
    for (int p = 0; p < 2; p++) drv[p] = c_idle();

    phase = "R9";
    do_reset(3);

    phase = "R4";
    for (int i = 0; i < 8; i++) cyc(c_wr(i, pat(i)), c_wr(i + 8, pat(i + 50)));
    for (int i = 0; i < 8; i++) cyc(c_rd(i), c_rd(i + 8));
    cyc(c_wr(2, 18'h3ffff, 2'b01), c_wr(9, 18'h00000, 2'b10));
    cyc(c_rd(2), c_rd(9));
    cyc(c_wr(2, 18'h15555, 2'b10), c_wr(9, 18'h3ffff, 2'b00));
    cyc(c_rd(9), c_rd(2));
    flush();

    phase = "R1";
    cyc(c_rd(5), c_idle());
    cyc(c_idle(), c_rd(13));
    flush();

    phase = "R2";
    cyc(c_offwr(3, 18'h3f0f0, 1'b0), c_offwr(10, 18'h0f0f0, 1'b1));
    cyc(c_rd(3), c_rd(10));
    cyc(c_offwr(3, 18'h0, 1'b1), c_idle());
    flush();

    phase = "R3";
    cyc(c_rd(1), c_rd(1));
    cyc(c_idle(), c_idle());
    cyc(c_rd(4), c_rd(12));
    cyc(c_idle(), c_rd(6));
    cyc(c_rd(7), c_idle());
    flush();

    phase = "R5";
    cyc(c_rd(4, 1'b0), c_rd(4, 1'b1));
    cyc(c_wr(44, pat(44)), c_rd(4, 1'b0));
    flush();

    phase = "R6";
    cyc(c_rd(6), c_rd(7));
    cyc(c_wr(40, pat(40)), c_wr(41, pat(41)));
    cyc(c_wr(42, pat(42)), c_wr(43, pat(43)));
    flush();

    phase = "R7";
    cyc(c_wr(20, 18'h2aaaa), c_idle());
    cyc(c_wr(20, 18'h15555), c_rd(20));
    cyc(c_idle(), c_rd(20));
    cyc(c_rd(21), c_wr(21, 18'h0abcd));
    cyc(c_rd(21), c_idle());
    flush();

    phase = "R8";
    cyc(c_rd(11), c_rd(11));
    cyc(c_wr(12, 18'h1f00f), c_idle());
    cyc(c_idle(), c_rd(12));
    cyc(c_rd(12), c_rd(12));
    flush();

    phase = "R10";
    cyc(c_wr(31, 18'h13579), c_wr(29, 18'h02468));
    cyc(c_wr(30, 18'h3ffff), c_wr(30, 18'h00001));
    cyc(c_rd(31), c_rd(29));
    cyc(c_rd(30), c_idle());
    cyc(c_wr(30, 18'h1c71c), c_idle());
    cyc(c_idle(), c_rd(30));
    flush();

    phase = "R9";
    cyc(c_rd(0), c_rd(8));
    do_reset(2);
    cyc(c_rd(0), c_rd(8));
    cyc(c_rd(3), c_rd(20));
    flush();

    phase = "R8 mixed";
    for (int n = 0; n < 400; n++) begin
      cmd_t ca;
      cmd_t cb;
      ca = rnd_cmd(seed);
      cb = rnd_cmd(seed);
      cyc(ca, cb);
    end
    flush();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule